// File: doc/BRIEF.md
# Asymmetric Release-Hold Button Debouncer

This block takes a mechanical pushbutton that pulls its line low when pressed, and produces a clean active-high pressed level. The pressed level rises as soon as the block samples the button low, with no delay. It falls only after the button has read released for a fixed run of consecutive samples. A shorter release run ends the moment the button reads low again, so contact bounce after a press or at release time never makes a gap in the output.

The block runs on a slow sampling clock: 100 Hz with a hold of 4 samples gives roughly 40 ms. Its input must already be synchronized to that clock, and any single-cycle edge pulse is made downstream.

Top module: `btn_debounce`

## Requirements
- R1: While reset is asserted (rst_n low), the output `pressed` is 0 and the release count is cleared.
- R2: The raw input is active low: `btn_n` = 0 means pressed and `btn_n` = 1 means released.
- R3: `pressed` is 1 from the first clock edge that samples `btn_n` = 0, with one register of latency.
- R4: Once `pressed` is 1, it returns to 0 only at the clock edge that samples the HOLD-th consecutive `btn_n` = 1. The default of parameter HOLD is 4.
- R5: A sample with `btn_n` = 0 during the release run restarts the count. `pressed` stays 1, and HOLD further consecutive released samples are then needed.
- R6: While `pressed` is 0, released samples have no effect and `pressed` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_n | input | 1 | Synchronized button level, low when pressed |
| pressed | output | 1 | Debounced pressed level, active high |

## Verification
A press sample and the final step of a release run can fall in the same cycle. This happens when the button reads low again on exactly the sample that would have been the HOLD-th released one. The bench sweeps every released-run length from 1 to HOLD+1, each followed by a press. It judges from a cycle-by-cycle model of the two rules that `pressed` never drops at that collision, and that it drops exactly at the HOLD-th sample when the run completes.

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic pressed
);
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD);

  logic          act;
  logic [CW-1:0] run;
  logic          last;

  assign act  = ~btn_n;
  assign last = (run == CW'(HOLD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pressed <= 1'b0;
      run     <= '0;
    end else if (act) begin
      pressed <= 1'b1;
      run     <= '0;
    end else if (pressed) begin
      if (last) begin
        pressed <= 1'b0;
        run     <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!pressed && run == '0));
  // R3
  press_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) !btn_n |=> pressed);
  // R5
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n) !btn_n |=> run == '0);
  // R6
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n) (!pressed && btn_n) |=> !pressed);
  // R4
  fall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pressed && !(btn_n && last)) |=> pressed);
endmodule

// File: tb/tb_btn_debounce.sv
module tb_btn_debounce;
  localparam int HOLD = 4;
  logic clk = 0, rst_n = 0, btn_n = 1;
  logic pressed;
  int checks = 0, errors = 0;
  bit exp_p = 0;
  int exp_run = 0;
  bit done = 0;

  btn_debounce #(.HOLD(HOLD)) dut (.clk(clk), .rst_n(rst_n), .btn_n(btn_n), .pressed(pressed));

  always #4 clk = ~clk;

  task automatic chk(input string req, input bit exp);
    checks++;
    if (pressed !== exp) begin
      errors++;
      $display("FAIL %s pressed=%0b expected=%0b", req, pressed, exp);
    end
  endtask

  // drive one sample, update model, check after edge
  task automatic step(input bit b, input string req);
    btn_n = b;
    @(posedge clk);
    if (!rst_n) begin exp_p = 0; exp_run = 0; end
    else if (!b) begin exp_p = 1; exp_run = 0; end
    else if (exp_p) begin
      if (exp_run == HOLD - 1) begin exp_p = 0; exp_run = 0; end
      else exp_run++;
    end
    #2 chk(req, exp_p);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    step(1, "R1"); step(0, "R1");
    rst_n = 1;
    step(1, "R6"); step(1, "R6"); step(1, "R6");
    step(0, "R3"); step(0, "R3");
    for (int n = 1; n <= HOLD + 1; n++) begin
      for (int k = 0; k < n; k++) step(1, (n < HOLD) ? "R5" : "R4");
      step(0, "R5");
    end
    for (int k = 0; k < HOLD; k++) step(1, "R4");
    step(1, "R6");
    for (int p = 0; p < 64; p++)
      for (int i = 0; i < 6; i++) step(p[i] ? 1'b1 : 1'b0, "R2");
    step(0, "R3");
    rst_n = 0; step(0, "R1"); step(1, "R1");
    rst_n = 1; step(1, "R6");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); checks++; errors++;
        $display("FAIL watchdog expired"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule